// File: doc/BRIEF.md
# Per-Destination End-of-Interrupt Acknowledge Tracker

This block follows one edge-triggered interrupt pin whose requester needs to know whether its previous tick has been acknowledged by every processor that took it. When a new assertion arrives and nothing is outstanding, the assertion is delivered. The tracker then remembers which destinations accepted it, in a bitmap, and how many of them still owe an end-of-interrupt (EOI), in a counter. Until that counter returns to zero, any further assertion is refused and reported as coalesced, so the requester can account for the lost tick.

EOIs arrive one destination at a time. An EOI clears that destination's bit and lowers the count only if the bit was set. A restore operation rebuilds the state after a state load. Each destination that the interrupt entry addresses is brought in line with a per-destination flag that says whether the vector is still pending at that destination. A synchronous clear empties the tracker. Choosing which destinations accept a delivery is done outside the block.

Top module: `eoi_ack_tracker`

## Requirements
- R1: A low `rst_n`, or a high `track_clear` at a clock edge, leaves `pend_count` at 0 and `pend_map` all zero after that edge. `underflow_err` is cleared only by `rst_n`.
- R2: `coalesced` is high exactly when `pend_count` is nonzero. `deliver_fire` equals `assert_req` AND NOT `coalesced`, and `assert_dropped` equals `assert_req` AND `coalesced`. All three are combinational in the same cycle.
- R3: A cycle with `deliver_fire` high loads `pend_map` with `accept_map`, and loads `pend_count` with the number of ones in `accept_map`, at the next edge. An all-zero `accept_map` leaves the tracker empty.
- R4: A dropped assertion, meaning `assert_req` while `coalesced` is high, does not change `pend_map` or `pend_count`.
- R5: An EOI (`eoi_valid` high) with an `eoi_dest` index whose bit in `pend_map` is 1 clears that bit and lowers `pend_count` by one at the next edge. Bit i of every map belongs to destination index i.
- R6: An EOI whose destination bit is 0, or whose index is N_DEST or above, changes neither `pend_map` nor `pend_count`.
- R7: On `restore_valid`, each destination i with `restore_match[i]`=1 is handled as follows. If `restore_pending[i]`=1 and its bit is 0, the bit is set and the count is incremented. If `restore_pending[i]`=0 and its bit is 1, the bit is cleared and the count is decremented. Destinations with `restore_match[i]`=0 keep their bits.
- R8: When inputs act in the same cycle, the order of precedence is `track_clear`, then `restore_valid`, then delivery and EOI. Any input of lower precedence in that cycle is ignored.
- R9: `pend_count` never drops below zero. A decrement that would underflow leaves the count at 0 and sets the sticky `underflow_err`. This cannot happen under these rules, so `underflow_err` stays 0.
- R10: `pend_count` is ceil(log2(N_DEST+1)) bits wide. With the default N_DEST = 8, it is 4 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| track_clear | input | 1 | Synchronous clear of bitmap and counter |
| assert_req | input | 1 | New assertion on the tracked pin |
| accept_map | input | N_DEST | Destinations that accept the delivery in this cycle |
| eoi_valid | input | 1 | End-of-interrupt event |
| eoi_dest | input | IDX_W | Index of the destination that sends the EOI |
| restore_valid | input | 1 | Rebuild the state from the per-destination flags |
| restore_match | input | N_DEST | Destinations that the entry addresses |
| restore_pending | input | N_DEST | Destinations where the vector is still pending |
| coalesced | output | 1 | A new assertion would be coalesced |
| deliver_fire | output | 1 | The assertion in this cycle is delivered |
| assert_dropped | output | 1 | The assertion in this cycle is refused |
| pend_map | output | N_DEST | Destinations that still owe an EOI |
| pend_count | output | CNT_W | Number of outstanding EOIs |
| underflow_err | output | 1 | Sticky counter underflow flag |

## Verification
The assertions assume that every input is sampled at one clock edge and is acted on there. They assume that `accept_map` matters only in a cycle where the assertion fires. They also assume that state changes only through clear, restore, delivery and EOI. That is why the counter-equals-bitmap-population property is expected to hold at all times. Each property that checks a single operation excludes the inputs of higher precedence in the same cycle. The stimulus uses all inputs freely, including simultaneous clears, restores, deliveries and EOIs, and EOIs to destinations that are idle. The random EOI indices cover every valid destination.

// File: rtl/eat_pkg.sv
package eat_pkg;

  // operation selected for the current edge, highest precedence first
  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_CLEAR   = 3'd1,
    OP_RESTORE = 3'd2,
    OP_DELIVER = 3'd3,
    OP_EOI     = 3'd4
  } eat_op_e;

  localparam int unsigned MAX_DEST = 64;

  // population count of a zero-extended destination vector
  function automatic logic [6:0] pop64(input logic [MAX_DEST-1:0] v);
    logic [6:0] acc;
    acc = '0;
    for (int i = 0; i < MAX_DEST; i++) acc = acc + 7'(v[i]);
    return acc;
  endfunction

  // counter width for n destinations: ceil(log2(n+1))
  function automatic int unsigned cnt_width(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) < (n + 1)) w++;
    return w;
  endfunction

endpackage

// File: rtl/eat_gate.sv
module eat_gate #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             assert_req,
  input  logic [CNT_W-1:0] pend_count,
  output logic             busy,
  output logic             fire,
  output logic             drop
);
  always_comb begin
    busy = (pend_count != '0);
    fire = assert_req & ~busy;
    drop = assert_req & busy;
  end
endmodule

// File: rtl/eat_eoi.sv
module eat_eoi #(
  parameter int unsigned N_DEST = 8,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              eoi_valid,
  input  logic [IDX_W-1:0]  eoi_dest,
  input  logic [N_DEST-1:0] pend_map,
  output logic              hit,
  output logic [N_DEST-1:0] hit_mask
);
  logic [N_DEST-1:0] onehot;

  generate
    for (genvar g = 0; g < N_DEST; g++) begin : g_dec
      assign onehot[g] = (32'(eoi_dest) == g);
    end
  endgenerate

  always_comb begin
    hit_mask = eoi_valid ? (onehot & pend_map) : '0;
    hit      = |hit_mask;
  end
endmodule

// File: rtl/eat_restore.sv
module eat_restore #(
  parameter int unsigned N_DEST = 8
) (
  input  logic [N_DEST-1:0] pend_map,
  input  logic [N_DEST-1:0] match,
  input  logic [N_DEST-1:0] pending,
  output logic [N_DEST-1:0] set_mask,
  output logic [N_DEST-1:0] clr_mask,
  output logic [N_DEST-1:0] new_map
);
  always_comb begin
    set_mask = match &  pending & ~pend_map;
    clr_mask = match & ~pending &  pend_map;
    new_map  = (pend_map | set_mask) & ~clr_mask;
  end
endmodule

// File: rtl/eoi_ack_tracker.sv
module eoi_ack_tracker #(
  parameter int unsigned N_DEST = 8,
  parameter int unsigned IDX_W  = (N_DEST > 1) ? $clog2(N_DEST) : 1,
  parameter int unsigned CNT_W  = eat_pkg::cnt_width(N_DEST)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              track_clear,
  input  logic              assert_req,
  input  logic [N_DEST-1:0] accept_map,
  input  logic              eoi_valid,
  input  logic [IDX_W-1:0]  eoi_dest,
  input  logic              restore_valid,
  input  logic [N_DEST-1:0] restore_match,
  input  logic [N_DEST-1:0] restore_pending,
  output logic              coalesced,
  output logic              deliver_fire,
  output logic              assert_dropped,
  output logic [N_DEST-1:0] pend_map,
  output logic [CNT_W-1:0]  pend_count,
  output logic              underflow_err
);
  import eat_pkg::*;

  localparam int unsigned WIDE = CNT_W + 1;

  // internal events, named for the assertions
  logic              eoi_hit;
  logic [N_DEST-1:0] eoi_mask;
  logic [N_DEST-1:0] rs_set, rs_clr, rs_map;
  eat_op_e           op;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [N_DEST-1:0] map_nxt;
  logic              underflow_evt;

  eat_gate #(.CNT_W(CNT_W)) u_gate (
    .assert_req (assert_req),
    .pend_count (pend_count),
    .busy       (coalesced),
    .fire       (deliver_fire),
    .drop       (assert_dropped)
  );

  eat_eoi #(.N_DEST(N_DEST), .IDX_W(IDX_W)) u_eoi (
    .eoi_valid (eoi_valid),
    .eoi_dest  (eoi_dest),
    .pend_map  (pend_map),
    .hit       (eoi_hit),
    .hit_mask  (eoi_mask)
  );

  eat_restore #(.N_DEST(N_DEST)) u_restore (
    .pend_map (pend_map),
    .match    (restore_match),
    .pending  (restore_pending),
    .set_mask (rs_set),
    .clr_mask (rs_clr),
    .new_map  (rs_map)
  );

  // precedence: clear, restore, then delivery or EOI (mutually exclusive in effect)
  always_comb begin
    if (track_clear)        op = OP_CLEAR;
    else if (restore_valid) op = OP_RESTORE;
    else if (deliver_fire)  op = OP_DELIVER;
    else if (eoi_hit)       op = OP_EOI;
    else                    op = OP_IDLE;
  end

  always_comb begin
    logic [WIDE-1:0] up, down;
    up            = '0;
    down          = '0;
    cnt_nxt       = pend_count;
    map_nxt       = pend_map;
    underflow_evt = 1'b0;
    unique case (op)
      OP_CLEAR: begin
        cnt_nxt = '0;
        map_nxt = '0;
      end
      OP_RESTORE: begin
        up   = WIDE'(pend_count) + WIDE'(pop64(MAX_DEST'(rs_set)));
        down = WIDE'(pop64(MAX_DEST'(rs_clr)));
        if (down > up) begin
          underflow_evt = 1'b1;
          cnt_nxt       = '0;
        end else begin
          cnt_nxt = CNT_W'(up - down);
        end
        map_nxt = rs_map;
      end
      OP_DELIVER: begin
        cnt_nxt = CNT_W'(pop64(MAX_DEST'(accept_map)));
        map_nxt = accept_map;
      end
      OP_EOI: begin
        if (pend_count == '0) underflow_evt = 1'b1;
        else                  cnt_nxt = pend_count - 1'b1;
        map_nxt = pend_map & ~eoi_mask;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_count    <= '0;
      pend_map      <= '0;
      underflow_err <= 1'b0;
    end else begin
      pend_count <= cnt_nxt;
      pend_map   <= map_nxt;
      if (underflow_evt) underflow_err <= 1'b1;
    end
  end

  // ---------------- assertions ----------------
  assert_count_is_population_R9: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pend_count) == $countones(pend_map));

  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !underflow_evt);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_err |=> underflow_err);

  assert_clear_empties_R1: assert property (@(posedge clk) disable iff (!rst_n)
    track_clear |=> (pend_count == '0) && (pend_map == '0));

  assert_fire_loads_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (deliver_fire && !track_clear && !restore_valid) |=> pend_map == $past(accept_map));

  assert_fire_only_when_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    deliver_fire |-> (pend_map == '0));

  assert_drop_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (assert_dropped && !track_clear && !restore_valid && !eoi_valid)
      |=> $stable(pend_map) && $stable(pend_count));

  assert_eoi_hit_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_hit && !track_clear && !restore_valid)
      |=> pend_count == $past(pend_count) - 1'b1);

  assert_eoi_miss_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && !eoi_hit && !track_clear && !restore_valid && !deliver_fire)
      |=> $stable(pend_map) && $stable(pend_count));

  assert_restore_aligns_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_valid && !track_clear)
      |=> (pend_map & $past(restore_match)) == ($past(restore_pending) & $past(restore_match)));

endmodule

// File: tb/eoi_ack_tracker_bench.sv
`timescale 1ns/1ps
module eoi_ack_tracker_bench;
  localparam int N  = 8;
  localparam int IW = 3;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic track_clear = 0, assert_req = 0, eoi_valid = 0, restore_valid = 0;
  logic [N-1:0] accept_map = '0, restore_match = '0, restore_pending = '0;
  logic [IW-1:0] eoi_dest = '0;
  logic coalesced, deliver_fire, assert_dropped, underflow_err;
  logic [N-1:0] pend_map;
  logic [CW-1:0] pend_count;

  always #2.5 clk = ~clk;

  eoi_ack_tracker #(.N_DEST(N)) u_eoi_ack_tracker (
    .clk, .rst_n, .track_clear, .assert_req, .accept_map, .eoi_valid, .eoi_dest,
    .restore_valid, .restore_match, .restore_pending, .coalesced, .deliver_fire,
    .assert_dropped, .pend_map, .pend_count, .underflow_err
  );

  int checks = 0, fails = 0;
  bit done = 0;
  // behavioural reference state
  bit exp_pend [N];
  int exp_cnt = 0;
  string last_tag = "R1";

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  function automatic longint ref_map();
    longint m = 0;
    foreach (exp_pend[i]) if (exp_pend[i]) m |= (64'd1 << i);
    return m;
  endfunction

  task automatic check_state(input string tag);
    chk(longint'(pend_map) == ref_map(), tag, "pend_map", pend_map, ref_map());
    chk(int'(pend_count) == exp_cnt, tag, "pend_count", pend_count, exp_cnt);
    chk(underflow_err == 1'b0, "R9", "underflow_err", underflow_err, 0);
  endtask

  // one clock: drive at negedge, check combinational outputs, advance the model
  task automatic step(input bit a, input logic [N-1:0] acc, input bit ev, input int ed,
                      input bit rv, input logic [N-1:0] rm, input logic [N-1:0] rp, input bit clr);
    @(negedge clk);
    check_state(last_tag);
    assert_req = a; accept_map = acc; eoi_valid = ev; eoi_dest = IW'(ed);
    restore_valid = rv; restore_match = rm; restore_pending = rp; track_clear = clr;
    #1;
    chk(coalesced == (exp_cnt != 0), "R2", "coalesced", coalesced, exp_cnt != 0);
    chk(deliver_fire == (a && exp_cnt == 0), "R2", "deliver_fire", deliver_fire, a && exp_cnt == 0);
    chk(assert_dropped == (a && exp_cnt != 0), "R2", "assert_dropped", assert_dropped, a && exp_cnt != 0);
    if (clr) begin
      foreach (exp_pend[i]) exp_pend[i] = 0;
      exp_cnt = 0;
      last_tag = (rv || a || ev) ? "R8" : "R1";
    end else if (rv) begin
      for (int i = 0; i < N; i++) begin
        if (rm[i] && rp[i] && !exp_pend[i]) begin exp_pend[i] = 1; exp_cnt++; end
        else if (rm[i] && !rp[i] && exp_pend[i]) begin exp_pend[i] = 0; exp_cnt--; end
      end
      last_tag = (a || ev) ? "R8" : "R7";
    end else if (a && exp_cnt == 0) begin
      exp_cnt = 0;
      for (int i = 0; i < N; i++) begin exp_pend[i] = acc[i]; if (acc[i]) exp_cnt++; end
      last_tag = "R3";
    end else if (ev && ed < N && exp_pend[ed]) begin
      exp_pend[ed] = 0; exp_cnt--;
      last_tag = "R5";
    end else begin
      last_tag = a ? "R4" : (ev ? "R6" : "R2");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int w;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_state("R1");
    chk(coalesced == 0, "R1", "coalesced after reset", coalesced, 0);
    w = 1; while ((1 << w) < N + 1) w++;
    chk($bits(pend_count) == w, "R10", "count width", $bits(pend_count), w);
    rst_n = 1;
    // R3 delivery, then R4 drop, R5 hit, R6 miss and out-of-range style idle dest
    step(1, 8'b1011_0010, 0, 0, 0, '0, '0, 0);
    step(1, 8'b1111_1111, 0, 0, 0, '0, '0, 0);
    step(0, '0, 1, 1, 0, '0, '0, 0);
    step(0, '0, 1, 0, 0, '0, '0, 0);
    step(0, '0, 1, 1, 0, '0, '0, 0);
    // R7 restore: add dest 0, drop dest 7, leave dest 5 (not matched)
    step(0, '0, 0, 0, 1, 8'b1000_0001, 8'b0000_0001, 0);
    // R8 clear beats restore and delivery
    step(1, 8'hFF, 1, 4, 1, 8'hFF, 8'hFF, 1);
    // R3 empty accept map keeps tracker idle
    step(1, 8'h00, 0, 0, 0, '0, '0, 0);
    step(1, 8'h01, 0, 0, 0, '0, '0, 0);
    // R8 restore beats EOI in the same cycle
    step(0, '0, 1, 0, 1, 8'h02, 8'h02, 0);
    step(0, '0, 1, 0, 0, '0, '0, 0);
    step(0, '0, 1, 1, 0, '0, '0, 0);
    for (int k = 0; k < 4000; k++) begin
      step($urandom_range(0, 2) != 0, N'($urandom), $urandom_range(0, 1) == 1,
           $urandom_range(0, N - 1), $urandom_range(0, 15) == 0, N'($urandom), N'($urandom),
           $urandom_range(0, 63) == 0);
    end
    step(0, '0, 0, 0, 0, '0, '0, 0);
    @(negedge clk);
    check_state(last_tag);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule